// File: doc/BRIEF.md
# CAN Error Code Capture Unit

This block sits beside a CAN protocol engine and keeps the diagnostic record that software reads after a fault. When the engine flags a bus error, the unit stores the error class, whether the node was sending or receiving, and the five-bit code of the frame segment in which the fault was seen. When the engine reports lost arbitration, it stores the bit position at which the loss happened. Each capture freezes after its first event, so later faults cannot overwrite a record that software has not read yet. A read of the status word re-arms both captures.

The unit also keeps the transmit and receive error counters. The engine supplies increment pulses with a step size and decrement pulses. From the counters the unit derives three levels: warning, against a programmable limit; passive; and bus-off. Each level raises a one-cycle event pulse when it turns on. Software can load the counters, and loading zero clears both of them and also clears bus-off. The segment codes do not run in frame order (for example start of frame is 0x03, the data field 0x0A, ACK 0x19, overload 0x1C). The engine produces them and this unit stores them unchanged.

Top module: `can_err_capture`

## Requirements
- R1: After reset the status word, the counter word and all three event outputs read 0, and the warning limit is 96.
- R2: A bus_err_i pulse with the capture unlocked stores err_type_i in status bits 23:22 (0 bit, 1 form, 2 stuff, 3 other), err_dir_i in bit 21 (0 transmit, 1 receive) and seg_code_i in bits 20:16. All three are visible one cycle later.
- R3: An arb_lost_i pulse with the arbitration capture unlocked stores arb_pos_i in status bits 12:8, visible one cycle later.
- R4: Once an error or an arbitration capture holds a value, further events of the same kind are ignored until a stat_rd_i pulse. stat_rd_i leaves the stored values in place and re-arms both captures. An event in the same cycle as stat_rd_i is captured.
- R5: The counter word carries the transmit counter in bits 7:0 and the receive counter in bits 23:16. A cnt_wr_i pulse loads both counters from cnt_wr_tx_i and cnt_wr_rx_i and clears bus-off, so writing zero clears both counters.
- R6: Increments add the given step and stop at 255. Decrements subtract 1 and stop at 0. Neither wraps.
- R7: Per counter, a counter write overrides an increment, and an increment overrides a decrement in the same cycle.
- R8: Status bit 6 is 1 while either counter is at or above the warning limit (written through lim_wr_i). warn_evt_o is high for exactly the first cycle in which bit 6 reads 1.
- R9: Status bit 14 is 1 while either counter is 128 or more. passive_evt_o is high for exactly the first cycle in which it reads 1.
- R10: A transmit increment that would take the counter past 255 sets status bit 7 (bus-off) and holds the counter at 255. Reaching exactly 255 does not set it. Bus-off stays set until a counter write. busoff_evt_o pulses for one cycle when bit 7 turns on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_err_i | input | 1 | Bus-error event pulse |
| err_type_i | input | 2 | Error class of the event |
| err_dir_i | input | 1 | 0 transmit, 1 receive |
| seg_code_i | input | 5 | Frame segment code at the error |
| arb_lost_i | input | 1 | Arbitration-lost event pulse |
| arb_pos_i | input | 5 | Bit position of the arbitration loss |
| stat_rd_i | input | 1 | Status word read strobe, re-arms captures |
| tx_inc_i | input | 1 | Transmit counter increment |
| tx_step_i | input | 4 | Transmit increment step |
| tx_dec_i | input | 1 | Transmit counter decrement by 1 |
| rx_inc_i | input | 1 | Receive counter increment |
| rx_step_i | input | 4 | Receive increment step |
| rx_dec_i | input | 1 | Receive counter decrement by 1 |
| cnt_wr_i | input | 1 | Counter word write strobe |
| cnt_wr_tx_i | input | 8 | Transmit counter write value |
| cnt_wr_rx_i | input | 8 | Receive counter write value |
| lim_wr_i | input | 1 | Warning limit write strobe |
| lim_wr_val_i | input | 8 | Warning limit value |
| status_o | output | 32 | Status word |
| errcnt_o | output | 32 | Error counter word |
| warn_evt_o | output | 1 | Warning turn-on pulse |
| passive_evt_o | output | 1 | Passive turn-on pulse |
| busoff_evt_o | output | 1 | Bus-off turn-on pulse |

## Verification
Every input goes through one register stage. Captures, counter values and the three status levels therefore show on the outputs one cycle after the edge that samples the stimulus. The event pulses are formed from those registered levels, so each one is high in that same cycle and low again one cycle later. The bench drives inputs on the falling edge and reads results on the next falling edge. For each event it also checks the following cycle to confirm that the pulse lasts a single cycle. Freeze and re-arm checks compare the whole status word, so an ignored event that changed any field would be caught.

// File: rtl/can_err_capture.sv
module can_err_capture #(
  parameter int CW        = 8,
  parameter int SEGW      = 5,
  parameter int STEPW     = 4,
  parameter int LIM_RST   = 96,
  parameter int PASS_LVL  = 128
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             bus_err_i,
  input  logic [1:0]       err_type_i,
  input  logic             err_dir_i,
  input  logic [SEGW-1:0]  seg_code_i,
  input  logic             arb_lost_i,
  input  logic [SEGW-1:0]  arb_pos_i,
  input  logic             stat_rd_i,
  input  logic             tx_inc_i,
  input  logic [STEPW-1:0] tx_step_i,
  input  logic             tx_dec_i,
  input  logic             rx_inc_i,
  input  logic [STEPW-1:0] rx_step_i,
  input  logic             rx_dec_i,
  input  logic             cnt_wr_i,
  input  logic [CW-1:0]    cnt_wr_tx_i,
  input  logic [CW-1:0]    cnt_wr_rx_i,
  input  logic             lim_wr_i,
  input  logic [CW-1:0]    lim_wr_val_i,
  output logic [31:0]      status_o,
  output logic [31:0]      errcnt_o,
  output logic             warn_evt_o,
  output logic             passive_evt_o,
  output logic             busoff_evt_o
);
  localparam logic [CW-1:0] CMAX = {CW{1'b1}};
  localparam logic [CW-1:0] PLVL = CW'(PASS_LVL);

  logic [1:0]      cap_type;
  logic            cap_dir;
  logic [SEGW-1:0] cap_seg, cap_arb;
  logic            err_lock, arb_lock;
  logic [CW-1:0]   tx_cnt, rx_cnt, lim;
  logic            boff, warn_q, pas_q, boff_q;

  wire err_take = bus_err_i  && (!err_lock || stat_rd_i);
  wire arb_take = arb_lost_i && (!arb_lock || stat_rd_i);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cap_type <= '0; cap_dir <= 1'b0; cap_seg <= '0; cap_arb <= '0;
      err_lock <= 1'b0; arb_lock <= 1'b0;
    end else begin
      if (err_take) begin
        cap_type <= err_type_i; cap_dir <= err_dir_i; cap_seg <= seg_code_i;
      end
      if (arb_take) cap_arb <= arb_pos_i;
      err_lock <= err_take || (err_lock && !stat_rd_i);
      arb_lock <= arb_take || (arb_lock && !stat_rd_i);
    end
  end

  wire [CW:0] tx_sum = {1'b0, tx_cnt} + (CW+1)'(tx_step_i);
  wire [CW:0] rx_sum = {1'b0, rx_cnt} + (CW+1)'(rx_step_i);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tx_cnt <= '0; rx_cnt <= '0; boff <= 1'b0; lim <= CW'(LIM_RST);
    end else begin
      if (lim_wr_i) lim <= lim_wr_val_i;
      if (cnt_wr_i) begin
        tx_cnt <= cnt_wr_tx_i;
        rx_cnt <= cnt_wr_rx_i;
        boff   <= 1'b0;
      end else begin
        if (tx_inc_i) begin
          tx_cnt <= tx_sum[CW] ? CMAX : tx_sum[CW-1:0];
          if (tx_sum[CW]) boff <= 1'b1;
        end else if (tx_dec_i && tx_cnt != '0) begin
          tx_cnt <= tx_cnt - 1'b1;
        end
        if (rx_inc_i)
          rx_cnt <= rx_sum[CW] ? CMAX : rx_sum[CW-1:0];
        else if (rx_dec_i && rx_cnt != '0)
          rx_cnt <= rx_cnt - 1'b1;
      end
    end
  end

  wire err_sta = (tx_cnt >= lim) || (rx_cnt >= lim);
  wire passive = (tx_cnt >= PLVL) || (rx_cnt >= PLVL);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      warn_q <= 1'b0; pas_q <= 1'b0; boff_q <= 1'b0;
    end else begin
      warn_q <= err_sta; pas_q <= passive; boff_q <= boff;
    end
  end

  assign warn_evt_o    = err_sta && !warn_q;
  assign passive_evt_o = passive && !pas_q;
  assign busoff_evt_o  = boff && !boff_q;

  assign status_o = {8'h00, cap_type, cap_dir, cap_seg, 1'b0, passive, 1'b0,
                     cap_arb, boff, err_sta, 6'h00};
  assign errcnt_o = {8'h00, rx_cnt, 8'h00, tx_cnt};

  a_r4_err_freeze: assert property (@(posedge clk) disable iff (!rst_n)
    err_lock && !stat_rd_i |=> $stable(cap_type) && $stable(cap_dir) && $stable(cap_seg));
  a_r4_arb_freeze: assert property (@(posedge clk) disable iff (!rst_n)
    arb_lock && !stat_rd_i |=> $stable(cap_arb));
  a_r6_tx_no_wrap: assert property (@(posedge clk) disable iff (!rst_n)
    tx_inc_i && !cnt_wr_i |=> tx_cnt >= $past(tx_cnt));
  a_r6_rx_floor: assert property (@(posedge clk) disable iff (!rst_n)
    rx_dec_i && !rx_inc_i && !cnt_wr_i && rx_cnt == '0 |=> rx_cnt == '0);
  a_r5_clear: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_wr_i && cnt_wr_tx_i == '0 && cnt_wr_rx_i == '0 |=> tx_cnt == '0 && rx_cnt == '0 && !boff);
  a_r10_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    boff && !cnt_wr_i |=> boff);
  a_r8_one_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    warn_evt_o |=> !warn_evt_o);
  a_r9_one_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    passive_evt_o |=> !passive_evt_o);
endmodule

// File: tb/tb_can_err_capture.sv
`timescale 1ns/1ps
module tb_can_err_capture;
  logic clk = 1'b0, rst_n = 1'b0;
  logic bus_err_i = 0, err_dir_i = 0, arb_lost_i = 0, stat_rd_i = 0;
  logic [1:0] err_type_i = 0;
  logic [4:0] seg_code_i = 0, arb_pos_i = 0;
  logic tx_inc_i = 0, tx_dec_i = 0, rx_inc_i = 0, rx_dec_i = 0;
  logic [3:0] tx_step_i = 0, rx_step_i = 0;
  logic cnt_wr_i = 0, lim_wr_i = 0;
  logic [7:0] cnt_wr_tx_i = 0, cnt_wr_rx_i = 0, lim_wr_val_i = 0;
  logic [31:0] status_o, errcnt_o;
  logic warn_evt_o, passive_evt_o, busoff_evt_o;
  int errors = 0, checks = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  can_err_capture dut (.*);

  // {tx_inc, tx_step, tx_dec, rx_inc, rx_step, rx_dec, exp_tx, exp_rx}
  localparam logic [27:0] VEC [8] = '{
    {1'b1, 4'd8, 1'b0, 1'b0, 4'd0, 1'b0, 8'd8,  8'd0},
    {1'b0, 4'd0, 1'b0, 1'b1, 4'd1, 1'b0, 8'd8,  8'd1},
    {1'b1, 4'd8, 1'b0, 1'b1, 4'd8, 1'b0, 8'd16, 8'd9},
    {1'b0, 4'd0, 1'b1, 1'b0, 4'd0, 1'b0, 8'd15, 8'd9},
    {1'b0, 4'd0, 1'b0, 1'b0, 4'd0, 1'b1, 8'd15, 8'd8},
    {1'b1, 4'd8, 1'b1, 1'b0, 4'd0, 1'b0, 8'd23, 8'd8},
    {1'b0, 4'd0, 1'b0, 1'b0, 4'd0, 1'b1, 8'd23, 8'd7},
    {1'b1, 4'd1, 1'b0, 1'b0, 4'd0, 1'b0, 8'd24, 8'd7}
  };

  function automatic logic [31:0] mk(input logic [1:0] t, input logic d,
                                     input logic [4:0] s, input logic [4:0] a);
    return {8'h00, t, d, s, 3'b000, a, 8'h00};
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk); @(negedge clk);
    bus_err_i = 0; arb_lost_i = 0; stat_rd_i = 0;
    tx_inc_i = 0; tx_dec_i = 0; rx_inc_i = 0; rx_dec_i = 0;
    cnt_wr_i = 0; lim_wr_i = 0;
  endtask

  task automatic berr(input logic [1:0] t, input logic d, input logic [4:0] s);
    bus_err_i = 1; err_type_i = t; err_dir_i = d; seg_code_i = s;
  endtask

  task automatic wcnt(input logic [7:0] tx, input logic [7:0] rx);
    cnt_wr_i = 1; cnt_wr_tx_i = tx; cnt_wr_rx_i = rx;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk("R1 status", status_o, 32'h0);
    chk("R1 errcnt", errcnt_o, 32'h0);
    chk("R1 events", {29'h0, warn_evt_o, passive_evt_o, busoff_evt_o}, 32'h0);

    for (int i = 0; i < 8; i++) begin
      tx_inc_i = VEC[i][27]; tx_step_i = VEC[i][26:23]; tx_dec_i = VEC[i][22];
      rx_inc_i = VEC[i][21]; rx_step_i = VEC[i][20:17]; rx_dec_i = VEC[i][16];
      tick();
      chk("R6/R7 table", errcnt_o, {8'h00, VEC[i][7:0], 8'h00, VEC[i][15:8]});
    end

    berr(2'd2, 1'b1, 5'h0A); tick();
    chk("R2 capture", status_o, mk(2'd2, 1'b1, 5'h0A, 5'h00));
    berr(2'd1, 1'b0, 5'h19); tick();
    chk("R4 error frozen", status_o, mk(2'd2, 1'b1, 5'h0A, 5'h00));
    arb_lost_i = 1; arb_pos_i = 5'h15; tick();
    chk("R3 arb capture", status_o, mk(2'd2, 1'b1, 5'h0A, 5'h15));
    arb_lost_i = 1; arb_pos_i = 5'h03; tick();
    chk("R4 arb frozen", status_o, mk(2'd2, 1'b1, 5'h0A, 5'h15));
    stat_rd_i = 1; tick();
    chk("R4 read keeps values", status_o, mk(2'd2, 1'b1, 5'h0A, 5'h15));
    berr(2'd3, 1'b0, 5'h1C); arb_lost_i = 1; arb_pos_i = 5'h07; tick();
    chk("R4 re-armed capture", status_o, mk(2'd3, 1'b0, 5'h1C, 5'h07));
    stat_rd_i = 1; berr(2'd0, 1'b1, 5'h03); tick();
    chk("R4 same-cycle read", status_o, mk(2'd0, 1'b1, 5'h03, 5'h07));
    arb_lost_i = 1; arb_pos_i = 5'h1F; tick();
    chk("R4 arb re-armed by read", status_o, mk(2'd0, 1'b1, 5'h03, 5'h1F));

    wcnt(8'd9, 8'd5); tick();
    chk("R5 load", errcnt_o, 32'h0005_0009);
    wcnt(8'd0, 8'd0); tx_inc_i = 1; tx_step_i = 4'd8; rx_dec_i = 1; tick();
    chk("R5 R7 clear wins", errcnt_o, 32'h0);
    rx_dec_i = 1; tx_dec_i = 1; tick();
    chk("R6 floor at zero", errcnt_o, 32'h0);

    wcnt(8'd95, 8'd0); tick();
    chk("R8 below limit", {31'h0, status_o[6]}, 32'h0);
    tx_inc_i = 1; tx_step_i = 4'd1; tick();
    chk("R8 warn bit", {31'h0, status_o[6]}, 32'h1);
    chk("R8 warn pulse", {31'h0, warn_evt_o}, 32'h1);
    tick();
    chk("R8 pulse ends", {31'h0, warn_evt_o}, 32'h0);
    lim_wr_i = 1; lim_wr_val_i = 8'd200; tick();
    chk("R8 raised limit", {31'h0, status_o[6]}, 32'h0);

    for (int k = 0; k < 3; k++) begin
      tx_inc_i = 1; tx_step_i = 4'd8; tick();
    end
    chk("R9 at 120", {30'h0, status_o[14], passive_evt_o}, 32'h0);
    tx_inc_i = 1; tx_step_i = 4'd8; tick();
    chk("R9 passive", {30'h0, status_o[14], passive_evt_o}, 32'h3);
    tick();
    chk("R9 pulse ends", {31'h0, passive_evt_o}, 32'h0);

    wcnt(8'd247, 8'd0); tick();
    tx_inc_i = 1; tx_step_i = 4'd8; tick();
    chk("R10 exact 255 not bus-off", {status_o[7], 23'h0, errcnt_o[7:0]}, 32'h0000_00FF);
    wcnt(8'd250, 8'd0); tick();
    tx_inc_i = 1; tx_step_i = 4'd8; tick();
    chk("R10 bus-off", {status_o[7], busoff_evt_o, 22'h0, errcnt_o[7:0]}, 32'hC000_00FF);
    tx_dec_i = 1; tick();
    chk("R10 sticky", {status_o[7], busoff_evt_o, 22'h0, errcnt_o[7:0]}, 32'h8000_00FE);
    wcnt(8'd0, 8'd0); tick();
    chk("R10 R5 cleared by write", {31'h0, status_o[7]}, 32'h0);
    wcnt(8'd0, 8'd250); tick();
    rx_inc_i = 1; rx_step_i = 4'd8; tick();
    chk("R6 rx saturates", {status_o[7], errcnt_o[30:0]}, 32'h00FF_0000);

    finish_run();
  end
endmodule